// File: doc/BRIEF.md
# Six-Stage Instruction Pipeline Flow Controller

This block follows instructions through an in-order pipeline of six stages: instruction fetch, decode, operand address calculation, operand fetch, execute and result write. It carries no datapath values. Each stage holds a valid flag and a tag, which is the program-counter value of the instruction in that stage. Fetch runs sequentially from a program counter. There is no prediction, so branch direction is learned only when the branch sits in execute. A taken branch in execute, or an accepted interrupt, lets the execute instruction move on to write. The four younger stages are discarded in the same cycle, and fetch is steered to the branch target or to the interrupt vector.

The surrounding core supplies three things. The first is a global freeze. The second is the branch result of the instruction in execute. The third is an interrupt request with its vector. It also reports, for each cycle, whether operand fetch and result write need the single memory port. When both need it, write goes first. Write drains by one stage, and everything younger waits one cycle.

Top module: `pipe_flow_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all six stage valid flags are 0 and the fetch address is 0.
- R2: In an advancing cycle, each stage k (1..5) takes the content of stage k-1. Stage 0 takes valid=1 with tag equal to the fetch address, and the fetch address then increments by 1, wrapping at the tag width. Stage k sits at stage_valid_o[k] and stage_tag_o[k*TAG_W +: TAG_W], where 0 is fetch, 4 is execute and 5 is write.
- R3: Starting from an empty pipeline with no redirects, conflicts or freezes, all six valid flags are 1 after the sixth clock edge following reset. The first completion is signalled in that same cycle.
- R4: When br_taken_i is 1, stage 4 is valid and no freeze or interrupt applies, the next cycle shows the following. Stage 5 holds the branch. Stages 1 to 4 are invalid. Stage 0 holds br_target_i. The fetch address is br_target_i+1.
- R5: After a taken branch, the branch completes in the next cycle, and the following four cycles have no completion.
- R6: br_taken_i has no effect while stage 4 is invalid. The pipeline advances as in R2.
- R7: When irq_req_i is 1 and the block is not frozen, the flush is the same as in R4, but the redirect goes to irq_vector_i. The interrupt also wins over a taken branch in the same cycle.
- R8: When stage 3 and stage 5 are both valid and fo_mem_i and wb_mem_i are both 1, and there is no freeze or redirect, three things happen in the next cycle. Stage 5 is empty. Stages 0 to 4 are unchanged. The fetch address is unchanged.
- R9: While freeze_i is 1, all stage registers and the fetch address hold their values, and retire_o is 0.
- R10: retire_o is 1 exactly when stage 5 is valid and freeze_i is 0, with retire_tag_o equal to the stage 5 tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| freeze_i | input | 1 | Holds every stage and the fetch address |
| br_taken_i | input | 1 | Execute-stage instruction is a taken branch |
| br_target_i | input | TAG_W | Branch destination |
| irq_req_i | input | 1 | Interrupt request |
| irq_vector_i | input | TAG_W | Interrupt handler address |
| fo_mem_i | input | 1 | Operand-fetch stage needs memory this cycle |
| wb_mem_i | input | 1 | Write stage needs memory this cycle |
| stage_valid_o | output | 6 | Valid flag per stage |
| stage_tag_o | output | 6*TAG_W | Tag per stage, stage k at bits k*TAG_W |
| fetch_addr_o | output | TAG_W | Next address to fetch |
| retire_o | output | 1 | An instruction completes this cycle |
| retire_tag_o | output | TAG_W | Tag of the completing instruction |

## Verification
The assertions check five behaviours on every clock. These are the reset state, the hold under freeze, the shape of the pipeline after a branch redirect and after an interrupt redirect, the one-cycle drain on a memory conflict, and the rule that completion only happens from a valid write stage. Some properties span many cycles and cannot be seen one clock at a time. These include the six-cycle fill from empty, the four-cycle completion gap after a taken branch, the ignored branch while execute is empty, and the order of tags across long mixed runs. These are shown only by the bench's directed scenarios and by its behavioural model, which is compared on every clock.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
    localparam int NUM_STAGES = 6;
    localparam int ST_FETCH   = 0;
    localparam int ST_OPFETCH = 3;
    localparam int ST_EXEC    = 4;
    localparam int ST_WRITE   = 5;

    typedef enum logic [1:0] {
        ACT_HOLD     = 2'd0,
        ACT_SHIFT    = 2'd1,
        ACT_REDIRECT = 2'd2,
        ACT_WB_ONLY  = 2'd3
    } pfc_action_e;

    function automatic logic mem_clash(input logic fo_v, input logic fo_m,
                                       input logic wb_v, input logic wb_m);
        return fo_v & fo_m & wb_v & wb_m;
    endfunction
endpackage

// File: rtl/pfc_hazard.sv
module pfc_hazard
    import pfc_pkg::*;
(
    input  logic        freeze_i,
    input  logic        irq_req_i,
    input  logic        br_taken_i,
    input  logic        ex_valid_i,
    input  logic        fo_valid_i,
    input  logic        fo_mem_i,
    input  logic        wb_valid_i,
    input  logic        wb_mem_i,
    output pfc_action_e action_o,
    output logic        use_vector_o
);
    always_comb begin
        use_vector_o = 1'b0;
        if (freeze_i) begin
            action_o = ACT_HOLD;
        end else if (irq_req_i) begin
            action_o     = ACT_REDIRECT;
            use_vector_o = 1'b1;
        end else if (br_taken_i && ex_valid_i) begin
            action_o = ACT_REDIRECT;
        end else if (mem_clash(fo_valid_i, fo_mem_i, wb_valid_i, wb_mem_i)) begin
            action_o = ACT_WB_ONLY;
        end else begin
            action_o = ACT_SHIFT;
        end
    end
endmodule

// File: rtl/pfc_fetch.sv
module pfc_fetch
    import pfc_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  pfc_action_e      action_i,
    input  logic [TAG_W-1:0] redirect_i,
    output logic [TAG_W-1:0] pc_o
);
    localparam logic [TAG_W-1:0] ONE = TAG_W'(1);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pc_o <= '0;
        end else begin
            case (action_i)
                ACT_SHIFT:    pc_o <= pc_o + ONE;
                ACT_REDIRECT: pc_o <= redirect_i + ONE;
                default:      pc_o <= pc_o;
            endcase
        end
    end
endmodule

// File: rtl/pfc_stage.sv
module pfc_stage
    import pfc_pkg::*;
#(
    parameter int TAG_W = 16,
    parameter int IDX   = 0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  pfc_action_e      action_i,
    input  logic             in_valid_i,
    input  logic [TAG_W-1:0] in_tag_i,
    output logic             valid_o,
    output logic [TAG_W-1:0] tag_o
);
    localparam bit KEEPS_ON_FLUSH = (IDX == ST_FETCH) || (IDX == ST_WRITE);
    localparam bit IS_WRITE       = (IDX == ST_WRITE);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
        end else begin
            case (action_i)
                ACT_SHIFT: begin
                    valid_o <= in_valid_i;
                    tag_o   <= in_tag_i;
                end
                ACT_REDIRECT: begin
                    if (KEEPS_ON_FLUSH) begin
                        valid_o <= in_valid_i;
                        tag_o   <= in_tag_i;
                    end else begin
                        valid_o <= 1'b0;
                    end
                end
                ACT_WB_ONLY: begin
                    if (IS_WRITE) valid_o <= 1'b0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pipe_flow_ctrl.sv
module pipe_flow_ctrl
    import pfc_pkg::*;
#(
    parameter int TAG_W = 16
) (
    input  logic                        clk_i,
    input  logic                        rst_i,
    input  logic                        freeze_i,
    input  logic                        br_taken_i,
    input  logic [TAG_W-1:0]            br_target_i,
    input  logic                        irq_req_i,
    input  logic [TAG_W-1:0]            irq_vector_i,
    input  logic                        fo_mem_i,
    input  logic                        wb_mem_i,
    output logic [NUM_STAGES-1:0]       stage_valid_o,
    output logic [NUM_STAGES*TAG_W-1:0] stage_tag_o,
    output logic [TAG_W-1:0]            fetch_addr_o,
    output logic                        retire_o,
    output logic [TAG_W-1:0]            retire_tag_o
);
    pfc_action_e      action;
    logic             use_vector;
    logic [TAG_W-1:0] redirect_addr;
    logic [TAG_W-1:0] pc;
    logic [TAG_W-1:0] entry_tag;

    pfc_hazard u_hazard (
        .freeze_i     (freeze_i),
        .irq_req_i    (irq_req_i),
        .br_taken_i   (br_taken_i),
        .ex_valid_i   (stage_valid_o[ST_EXEC]),
        .fo_valid_i   (stage_valid_o[ST_OPFETCH]),
        .fo_mem_i     (fo_mem_i),
        .wb_valid_i   (stage_valid_o[ST_WRITE]),
        .wb_mem_i     (wb_mem_i),
        .action_o     (action),
        .use_vector_o (use_vector)
    );

    assign redirect_addr = use_vector ? irq_vector_i : br_target_i;
    assign entry_tag     = (action == ACT_REDIRECT) ? redirect_addr : pc;

    pfc_fetch #(.TAG_W(TAG_W)) u_fetch (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .action_i   (action),
        .redirect_i (redirect_addr),
        .pc_o       (pc)
    );

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        logic             in_v;
        logic [TAG_W-1:0] in_t;
        if (k == 0) begin : g_head
            assign in_v = 1'b1;
            assign in_t = entry_tag;
        end else begin : g_body
            assign in_v = stage_valid_o[k-1];
            assign in_t = stage_tag_o[(k-1)*TAG_W +: TAG_W];
        end
        pfc_stage #(.TAG_W(TAG_W), .IDX(k)) u_st (
            .clk_i      (clk_i),
            .rst_i      (rst_i),
            .action_i   (action),
            .in_valid_i (in_v),
            .in_tag_i   (in_t),
            .valid_o    (stage_valid_o[k]),
            .tag_o      (stage_tag_o[k*TAG_W +: TAG_W])
        );
    end

    assign fetch_addr_o = pc;
    assign retire_o     = stage_valid_o[ST_WRITE] & (action != ACT_HOLD);
    assign retire_tag_o = stage_tag_o[ST_WRITE*TAG_W +: TAG_W];
endmodule

// File: rtl/pipe_flow_ctrl_chk.sv
module pipe_flow_ctrl_chk #(
    parameter int TAG_W = 16
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               freeze_i,
    input logic               br_taken_i,
    input logic [TAG_W-1:0]   br_target_i,
    input logic               irq_req_i,
    input logic [TAG_W-1:0]   irq_vector_i,
    input logic               fo_mem_i,
    input logic               wb_mem_i,
    input logic [5:0]         stage_valid_o,
    input logic [6*TAG_W-1:0] stage_tag_o,
    input logic [TAG_W-1:0]   fetch_addr_o,
    input logic               retire_o,
    input logic [TAG_W-1:0]   retire_tag_o
);
    logic [TAG_W-1:0] tag0;
    logic             clash;
    assign tag0  = stage_tag_o[TAG_W-1:0];
    assign clash = stage_valid_o[3] & fo_mem_i & stage_valid_o[5] & wb_mem_i;

    p_reset_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (stage_valid_o == 6'b0 && fetch_addr_o == '0));

    p_freeze_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        freeze_i |=> ($stable(stage_valid_o) && $stable(stage_tag_o) && $stable(fetch_addr_o)));

    p_branch_flush_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (br_taken_i && stage_valid_o[4] && !freeze_i && !irq_req_i) |=>
        (stage_valid_o[4:0] == 5'b00001 && stage_valid_o[5] && tag0 == $past(br_target_i)
         && fetch_addr_o == $past(br_target_i) + TAG_W'(1)));

    p_irq_flush_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_req_i && !freeze_i) |=>
        (stage_valid_o[4:0] == 5'b00001 && tag0 == $past(irq_vector_i)
         && fetch_addr_o == $past(irq_vector_i) + TAG_W'(1)));

    p_mem_drain_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (clash && !freeze_i && !irq_req_i && !(br_taken_i && stage_valid_o[4])) |=>
        (!stage_valid_o[5] && $stable(fetch_addr_o) && $stable(stage_valid_o[4:0])));

    p_retire_src_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        retire_o |-> (stage_valid_o[5] && !freeze_i && retire_tag_o == stage_tag_o[5*TAG_W +: TAG_W]));
endmodule

bind pipe_flow_ctrl pipe_flow_ctrl_chk #(.TAG_W(TAG_W)) chk_i (
    .clk_i(clk_i), .rst_i(rst_i), .freeze_i(freeze_i), .br_taken_i(br_taken_i),
    .br_target_i(br_target_i), .irq_req_i(irq_req_i), .irq_vector_i(irq_vector_i),
    .fo_mem_i(fo_mem_i), .wb_mem_i(wb_mem_i), .stage_valid_o(stage_valid_o),
    .stage_tag_o(stage_tag_o), .fetch_addr_o(fetch_addr_o), .retire_o(retire_o),
    .retire_tag_o(retire_tag_o)
);

// File: tb/pipe_flow_ctrl_tb_top.sv
`timescale 1ns/1ps
module pipe_flow_ctrl_tb_top;
    localparam int W = 16;

    logic clk_i = 1'b0;
    logic rst_i = 1'b1;
    logic freeze_i = 1'b0, br_taken_i = 1'b0, irq_req_i = 1'b0;
    logic fo_mem_i = 1'b0, wb_mem_i = 1'b0;
    logic [W-1:0] br_target_i = '0, irq_vector_i = '0;
    logic [5:0]   stage_valid_o;
    logic [6*W-1:0] stage_tag_o;
    logic [W-1:0] fetch_addr_o, retire_tag_o;
    logic         retire_o;

    always #2.5 clk_i = ~clk_i;

    pipe_flow_ctrl #(.TAG_W(W)) dut_i (.*);

    int checks = 0, fails = 0;
    bit mv[6];
    logic [W-1:0] mt[6];
    logic [W-1:0] mpc;
    bit last_ret;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare_state(input string req);
        for (int k = 0; k < 6; k++) begin
            chk(stage_valid_o[k] == mv[k], req, $sformatf("valid[%0d]", k), stage_valid_o[k], mv[k]);
            if (mv[k])
                chk(stage_tag_o[k*W +: W] == mt[k], req, $sformatf("tag[%0d]", k),
                    stage_tag_o[k*W +: W], mt[k]);
        end
        chk(fetch_addr_o == mpc, req, "fetch_addr", fetch_addr_o, mpc);
    endtask

    // One clock: drive at negedge, check completion, advance the model, check state.
    task automatic step(input string req, input bit frz, input bit br, input logic [W-1:0] tgt,
                        input bit irq, input logic [W-1:0] vec, input bit fom, input bit wbm);
        bit nv[6];
        logic [W-1:0] nt[6];
        logic [W-1:0] npc;
        bit exp_ret;
        freeze_i = frz; br_taken_i = br; br_target_i = tgt;
        irq_req_i = irq; irq_vector_i = vec; fo_mem_i = fom; wb_mem_i = wbm;
        #1;
        exp_ret = mv[5] && !frz;
        chk(retire_o == exp_ret, "R10", "retire_o", retire_o, exp_ret);
        if (exp_ret) chk(retire_tag_o == mt[5], "R10", "retire_tag", retire_tag_o, mt[5]);
        last_ret = retire_o;
        for (int k = 0; k < 6; k++) begin nv[k] = mv[k]; nt[k] = mt[k]; end
        npc = mpc;
        if (!frz) begin
            if (irq || (br && mv[4])) begin
                nv[5] = mv[4]; nt[5] = mt[4];
                for (int k = 1; k < 5; k++) nv[k] = 1'b0;
                nv[0] = 1'b1; nt[0] = irq ? vec : tgt;
                npc = nt[0] + 1'b1;
            end else if (mv[3] && fom && mv[5] && wbm) begin
                nv[5] = 1'b0;
            end else begin
                for (int k = 5; k > 0; k--) begin nv[k] = mv[k-1]; nt[k] = mt[k-1]; end
                nv[0] = 1'b1; nt[0] = mpc;
                npc = mpc + 1'b1;
            end
        end
        @(posedge clk_i);
        @(negedge clk_i);
        for (int k = 0; k < 6; k++) begin mv[k] = nv[k]; mt[k] = nt[k]; end
        mpc = npc;
        compare_state(req);
    endtask

    task automatic adv(input string req);
        step(req, 0, 0, '0, 0, '0, 0, 0);
    endtask

    task automatic do_reset();
        rst_i = 1'b1;
        repeat (2) @(negedge clk_i);
        rst_i = 1'b0;
        for (int k = 0; k < 6; k++) begin mv[k] = 0; mt[k] = '0; end
        mpc = '0;
        compare_state("R1");
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int gap;
        @(negedge clk_i);
        do_reset();
        // R3: fill from empty, six valid after six edges, first completion then
        for (int i = 0; i < 6; i++) adv("R2");
        chk(stage_valid_o == 6'h3F, "R3", "full after 6", stage_valid_o, 6'h3F);
        adv("R3");
        chk(last_ret == 1'b1, "R3", "first completion", last_ret, 1);
        for (int i = 0; i < 3; i++) adv("R2");
        // R4/R5: taken branch, then four-cycle gap
        step("R4", 0, 1, 16'h0100, 0, '0, 0, 0);
        chk(stage_valid_o == 6'b100001, "R4", "shape", stage_valid_o, 6'b100001);
        adv("R5");
        chk(last_ret == 1'b1, "R5", "branch completes", last_ret, 1);
        gap = 0;
        for (int i = 0; i < 4; i++) begin adv("R5"); gap += last_ret; end
        chk(gap == 0, "R5", "completions in gap", gap, 0);
        adv("R5");
        chk(last_ret == 1'b1, "R5", "target completes", last_ret, 1);
        // R6: branch ignored while execute empty
        step("R4", 0, 1, 16'h0200, 0, '0, 0, 0);
        step("R6", 0, 1, 16'h0BAD, 0, '0, 0, 0);
        step("R6", 0, 1, 16'h0BAD, 0, '0, 0, 0);
        chk(fetch_addr_o == 16'h0203, "R6", "fetch_addr", fetch_addr_o, 16'h0203);
        for (int i = 0; i < 4; i++) adv("R2");
        // R7: interrupt beats branch
        step("R7", 0, 1, 16'h0300, 1, 16'h8000, 0, 0);
        chk(stage_tag_o[W-1:0] == 16'h8000, "R7", "vector fetched", stage_tag_o[W-1:0], 16'h8000);
        for (int i = 0; i < 6; i++) adv("R2");
        // R8: memory clash, then no clash with only one side asking
        step("R8", 0, 0, '0, 0, '0, 1, 1);
        chk(stage_valid_o[5] == 1'b0, "R8", "write drained", stage_valid_o[5], 0);
        step("R8", 0, 0, '0, 0, '0, 1, 0);
        adv("R2");
        step("R8", 0, 0, '0, 0, '0, 1, 1);
        // R9: freeze holds everything
        step("R9", 1, 1, 16'h0400, 1, 16'h9000, 1, 1);
        step("R9", 1, 0, '0, 0, '0, 0, 0);
        chk(last_ret == 1'b0, "R9", "no completion frozen", last_ret, 0);
        // R2 wrap of fetch address
        step("R4", 0, 1, 16'hFFFE, 0, '0, 0, 0);
        for (int i = 0; i < 3; i++) adv("R2");
        chk(fetch_addr_o == 16'h0002, "R2", "wrap", fetch_addr_o, 16'h0002);
        // Mixed stimulus compared against the model on every clock
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 99);
            step("R2", r < 8, r >= 8 && r < 16, W'($urandom), r == 20,
                 W'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        end
        // R1 again after reset mid-run
        rst_i = 1'b1;
        @(negedge clk_i);
        @(negedge clk_i);
        rst_i = 1'b0;
        chk(stage_valid_o == 6'b0, "R1", "valid after reset", stage_valid_o, 0);
        chk(fetch_addr_o == '0, "R1", "fetch_addr after reset", fetch_addr_o, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule